// File: doc/BRIEF.md
# Reset-Time Memory Access Mode Sequencer

This block decides, on every exit from reset, how a small microcontroller reaches its program memory and which functions its I/O pins take. It samples two strap pins once, waits for the reset source's wake-up delay to end, and then reads a mode byte and a 16-bit start vector. The straps choose whether these three bytes come from on-chip ROM or over the external bus.

The mode byte is then decoded together with the straps. A legal pair selects one of three operating modes. The block then enables the external address/data bus and strobes, or general-purpose ports, and routes the three shared control pins. After that it gives the CPU a one-cycle run strobe. An illegal strap or mode byte parks the block in an error state. In that state the pins stay high-impedance and the CPU stays held.

Top module: `boot_mode_seq`

## Requirements
- R1: The straps are sampled once, in the first cycle after reset release. No memory read is issued before `wake_done_i` is seen high. Changes on `strap_i` after the sample have no effect.
- R2: Strap `strap_i==2'b00` fetches from internal ROM, with `rd_ext_o=0`. Strap `2'b10` (bit0 low, bit1 high) fetches over the external bus, with `rd_ext_o=1`.
- R3: Strap values `2'b01` and `2'b11` raise `err_o` without any memory read.
- R4: Exactly three reads are made, at `BASE_ADDR`, `BASE_ADDR+1` and `BASE_ADDR+2`. Each read keeps its address and `rd_req_o` high until `rd_valid_i` is seen.
- R5: `vec_o` is `{byte at BASE_ADDR+1, byte at BASE_ADDR+2}`, so the first vector byte is the high half (default `VEC_HI_FIRST=1`).
- R6: `mode_o` reads 0 until configured. Internal strap with byte 00h gives 1 (single-chip). External strap with byte 01h gives 2 (external ROM). Internal strap with byte 01h gives 3 (internal ROM with external bus).
- R7: Any other strap/byte pairing raises `err_o`, keeps `cpu_hold_o` high and never pulses `run_o`.
- R8: During reset, during the whole sequence and in the error state, `pins_hiz_o=1` and `mode_o=0`.
- R9: In single-chip mode `port_en_o=1` and `bus_en_o=0`. In either bus mode `bus_en_o=1` and `port_en_o=0`.
- R10: In a bus mode the shared pins follow `shpin_bus_sel_i`: 1 gives `shpin_bus_o=1`, and 0 gives `shpin_port_o=1`. Outside bus modes both outputs are 0.
- R11: `run_o` is high for exactly one cycle, after the pin configuration is applied. `cpu_hold_o` is low from that cycle on.
- R12: Asserting `rst_n` low at any point, including mid-fetch, at once returns the pins to high-impedance, drops `rd_req_o`, and restarts the sequence at the strap sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Mode strap pins (bit0 first pin, bit1 second pin) |
| wake_done_i | input | 1 | Wake-up delay of the reset source has elapsed |
| rd_req_o | output | 1 | Read request |
| rd_ext_o | output | 1 | 1 selects the external bus, 0 selects internal ROM |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data |
| shpin_bus_sel_i | input | 1 | Bus pin control: shared pins as bus control (1) or output ports (0) |
| mode_o | output | 2 | Decoded memory access mode |
| err_o | output | 1 | Prohibited strap or mode byte |
| pins_hiz_o | output | 1 | All I/O pins high-impedance |
| port_en_o | output | 1 | I/O pins act as direction-register ports |
| bus_en_o | output | 1 | Address, data, strobes, clock and ready pins active |
| shpin_bus_o | output | 1 | Shared pins drive bus control |
| shpin_port_o | output | 1 | Shared pins act as output-only ports |
| vec_o | output | 2*DATA_W | Fetched start vector |
| run_o | output | 1 | One-cycle run strobe |
| cpu_hold_o | output | 1 | CPU held in reset |

## Verification
The assertions assume that `rd_valid_i` is only raised while `rd_req_o` is high. They also assume it lasts a single cycle per read. They further assume that `rst_n` is the only way back to the start. The memory model in the bench answers only an open request. It drops valid in the cycle after giving it and waits a latency of zero to two cycles before each answer. This keeps the handshake within those assumptions while still exercising held addresses.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

   typedef enum logic [2:0] {
      ST_PINS, ST_WAIT, ST_FETCH, ST_CHECK, ST_CFG, ST_GO, ST_RUN, ST_ERR
   } seq_state_t;

   typedef enum logic [1:0] {
      MD_NONE   = 2'd0,
      MD_SINGLE = 2'd1,
      MD_EXTROM = 2'd2,
      MD_INTBUS = 2'd3
   } mem_mode_t;

   typedef enum logic [1:0] {
      SRC_INT = 2'd0,
      SRC_EXT = 2'd1,
      SRC_BAD = 2'd2
   } strap_cls_t;

   localparam int unsigned FETCH_BYTES = 3;

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
   import boot_mode_pkg::*;
#(
   parameter logic [1:0] INT_CODE = 2'b00,
   parameter logic [1:0] EXT_CODE = 2'b10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_i,
   input  logic [1:0] strap_i,
   output strap_cls_t cls_now_o,
   output strap_cls_t cls_o
);

   generate
      if (INT_CODE == EXT_CODE) begin : g_bad_codes
         $error("boot_strap_latch: strap codes must differ");
      end
   endgenerate

   always_comb begin
      if (strap_i == INT_CODE)      cls_now_o = SRC_INT;
      else if (strap_i == EXT_CODE) cls_now_o = SRC_EXT;
      else                          cls_now_o = SRC_BAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cls_o <= SRC_BAD;
      else if (sample_i) cls_o <= cls_now_o;
   end

endmodule

// File: rtl/boot_fetch.sv
module boot_fetch #(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned BASE_ADDR    = 'hFFFD,
   parameter bit          VEC_HI_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   output logic                rd_req_o,
   output logic [ADDR_W-1:0]   rd_addr_o,
   input  logic                rd_valid_i,
   input  logic [DATA_W-1:0]   rd_data_i,
   output logic                done_o,
   output logic [DATA_W-1:0]   mode_byte_o,
   output logic [2*DATA_W-1:0] vec_o
);

   localparam int unsigned IDX_W = 2;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(boot_mode_pkg::FETCH_BYTES - 1);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

   generate
      if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_aw
         $error("boot_fetch: ADDR_W out of range");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("boot_fetch: DATA_W too small");
      end
      if (ADDR_W < 32 && (BASE_ADDR + 2) >= (1 << ADDR_W)) begin : g_bad_base
         $error("boot_fetch: fetch window exceeds address space");
      end
   endgenerate

   logic             busy_q;
   logic             done_q;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_W-1:0] b0_q, b1_q, b2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         b0_q   <= '0;
         b1_q   <= '0;
         b2_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end else if (busy_q && rd_valid_i) begin
            case (idx_q)
               2'd0:    b0_q <= rd_data_i;
               2'd1:    b1_q <= rd_data_i;
               default: b2_q <= rd_data_i;
            endcase
            if (idx_q == LAST_IDX) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign rd_req_o    = busy_q;
   assign rd_addr_o   = BASE_V + ADDR_W'(idx_q);
   assign done_o      = done_q;
   assign mode_byte_o = b0_q;

   generate
      if (VEC_HI_FIRST) begin : g_hi_first
         assign vec_o = {b1_q, b2_q};
      end else begin : g_lo_first
         assign vec_o = {b2_q, b1_q};
      end
   endgenerate

endmodule

// File: rtl/boot_decode.sv
module boot_decode
   import boot_mode_pkg::*;
#(
   parameter int unsigned      DATA_W    = 8,
   parameter logic [DATA_W-1:0] MB_SINGLE = 'h00,
   parameter logic [DATA_W-1:0] MB_BUS    = 'h01
) (
   input  strap_cls_t        cls_i,
   input  logic [DATA_W-1:0] mode_byte_i,
   output mem_mode_t         mode_o,
   output logic              bad_o
);

   generate
      if (MB_SINGLE == MB_BUS) begin : g_bad_mb
         $error("boot_decode: mode byte codes must differ");
      end
   endgenerate

   always_comb begin
      mode_o = MD_NONE;
      bad_o  = 1'b1;
      unique case (cls_i)
         SRC_INT: begin
            if (mode_byte_i == MB_SINGLE) begin
               mode_o = MD_SINGLE;
               bad_o  = 1'b0;
            end else if (mode_byte_i == MB_BUS) begin
               mode_o = MD_INTBUS;
               bad_o  = 1'b0;
            end
         end
         SRC_EXT: begin
            if (mode_byte_i == MB_BUS) begin
               mode_o = MD_EXTROM;
               bad_o  = 1'b0;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/boot_pinmap.sv
module boot_pinmap
   import boot_mode_pkg::*;
(
   input  logic      cfg_active_i,
   input  mem_mode_t mode_i,
   input  logic      sel_i,
   output logic      hiz_o,
   output logic      port_en_o,
   output logic      bus_en_o,
   output logic      sh_bus_o,
   output logic      sh_port_o
);

   logic bus_mode;

   assign bus_mode  = (mode_i == MD_EXTROM) || (mode_i == MD_INTBUS);
   assign hiz_o     = !cfg_active_i;
   assign port_en_o = cfg_active_i && (mode_i == MD_SINGLE);
   assign bus_en_o  = cfg_active_i && bus_mode;
   assign sh_bus_o  = bus_en_o && sel_i;
   assign sh_port_o = bus_en_o && !sel_i;

endmodule

// File: rtl/boot_mode_seq.sv
module boot_mode_seq
   import boot_mode_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned BASE_ADDR    = 'hFFFD,
   parameter bit          VEC_HI_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          strap_i,
   input  logic                wake_done_i,
   output logic                rd_req_o,
   output logic                rd_ext_o,
   output logic [ADDR_W-1:0]   rd_addr_o,
   input  logic                rd_valid_i,
   input  logic [DATA_W-1:0]   rd_data_i,
   input  logic                shpin_bus_sel_i,
   output logic [1:0]          mode_o,
   output logic                err_o,
   output logic                pins_hiz_o,
   output logic                port_en_o,
   output logic                bus_en_o,
   output logic                shpin_bus_o,
   output logic                shpin_port_o,
   output logic [2*DATA_W-1:0] vec_o,
   output logic                run_o,
   output logic                cpu_hold_o
);

   seq_state_t state_q, state_d;
   strap_cls_t cls_now, cls_q;
   mem_mode_t  mode_q, dec_mode;
   logic       dec_bad;
   logic       fetch_start, fetch_done, cfg_active;
   logic [DATA_W-1:0] mode_byte;

   boot_strap_latch u_strap (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_i  (state_q == ST_PINS),
      .strap_i   (strap_i),
      .cls_now_o (cls_now),
      .cls_o     (cls_q)
   );

   assign fetch_start = (state_q == ST_WAIT) && wake_done_i;

   boot_fetch #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .BASE_ADDR    (BASE_ADDR),
      .VEC_HI_FIRST (VEC_HI_FIRST)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (fetch_start),
      .rd_req_o    (rd_req_o),
      .rd_addr_o   (rd_addr_o),
      .rd_valid_i  (rd_valid_i),
      .rd_data_i   (rd_data_i),
      .done_o      (fetch_done),
      .mode_byte_o (mode_byte),
      .vec_o       (vec_o)
   );

   boot_decode #(.DATA_W(DATA_W)) u_decode (
      .cls_i       (cls_q),
      .mode_byte_i (mode_byte),
      .mode_o      (dec_mode),
      .bad_o       (dec_bad)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_PINS:  state_d = (cls_now == SRC_BAD) ? ST_ERR : ST_WAIT;
         ST_WAIT:  if (wake_done_i) state_d = ST_FETCH;
         ST_FETCH: if (fetch_done) state_d = ST_CHECK;
         ST_CHECK: state_d = dec_bad ? ST_ERR : ST_CFG;
         ST_CFG:   state_d = ST_GO;
         ST_GO:    state_d = ST_RUN;
         ST_RUN:   state_d = ST_RUN;
         ST_ERR:   state_d = ST_ERR;
         default:  state_d = ST_ERR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PINS;
         mode_q  <= MD_NONE;
      end else begin
         state_q <= state_d;
         if (state_q == ST_CHECK && !dec_bad) mode_q <= dec_mode;
      end
   end

   assign cfg_active = (state_q == ST_CFG) || (state_q == ST_GO) || (state_q == ST_RUN);

   boot_pinmap u_pins (
      .cfg_active_i (cfg_active),
      .mode_i       (mode_q),
      .sel_i        (shpin_bus_sel_i),
      .hiz_o        (pins_hiz_o),
      .port_en_o    (port_en_o),
      .bus_en_o     (bus_en_o),
      .sh_bus_o     (shpin_bus_o),
      .sh_port_o    (shpin_port_o)
   );

   assign rd_ext_o   = (cls_q == SRC_EXT);
   assign mode_o     = cfg_active ? mode_q : MD_NONE;
   assign err_o      = (state_q == ST_ERR);
   assign run_o      = (state_q == ST_GO);
   assign cpu_hold_o = !((state_q == ST_GO) || (state_q == ST_RUN));

endmodule

// File: rtl/boot_mode_seq_chk.sv
module boot_mode_seq_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_valid_i,
   input logic [1:0]        mode_o,
   input logic              err_o,
   input logic              pins_hiz_o,
   input logic              port_en_o,
   input logic              bus_en_o,
   input logic              shpin_bus_o,
   input logic              shpin_port_o,
   input logic              run_o,
   input logic              cpu_hold_o
);

   // R4: a pending read keeps its address until valid
   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

   // R3 / R7: error is terminal and issues no reads
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
   p_err_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!rd_req_o && cpu_hold_o && !run_o));

   // R8: error state leaves pins high-impedance and mode unset
   p_err_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (pins_hiz_o && mode_o == 2'd0));

   // R9: bus and port functions never together
   p_bus_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en_o && port_en_o));

   // R10: shared pins have at most one role
   p_shared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({shpin_bus_o, shpin_port_o}));

   // R11: run is a single-cycle strobe, after configuration
   p_run_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |=> (!run_o && !cpu_hold_o));
   p_run_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (!pins_hiz_o && mode_o != 2'd0 && $past(!pins_hiz_o)));

endmodule

bind boot_mode_seq boot_mode_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_req_o     (rd_req_o),
   .rd_addr_o    (rd_addr_o),
   .rd_valid_i   (rd_valid_i),
   .mode_o       (mode_o),
   .err_o        (err_o),
   .pins_hiz_o   (pins_hiz_o),
   .port_en_o    (port_en_o),
   .bus_en_o     (bus_en_o),
   .shpin_bus_o  (shpin_bus_o),
   .shpin_port_o (shpin_port_o),
   .run_o        (run_o),
   .cpu_hold_o   (cpu_hold_o)
);

// File: tb/boot_mode_seq_bench.sv
module boot_mode_seq_bench;

   localparam int unsigned AW   = 16;
   localparam int unsigned DW   = 8;
   localparam int unsigned BASE = 'hFFFD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    strap = 2'b00;
   logic          wake = 1'b0;
   logic          rd_req, rd_ext, rd_valid = 1'b0;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data = '0;
   logic          shsel = 1'b0;
   logic [1:0]    mode;
   logic          err, hiz, port_en, bus_en, sh_bus, sh_port, run, hold;
   logic [15:0]   vec;

   int checks = 0;
   int fails  = 0;
   int lat_cfg = 0;
   logic [DW-1:0] mem_byte = '0;
   int nlog = 0;
   logic [AW-1:0] addr_log [8];
   logic          ext_log  [8];

   always #4 clk = ~clk;

   boot_mode_seq u_boot_mode_seq (
      .clk (clk), .rst_n (rst_n), .strap_i (strap), .wake_done_i (wake),
      .rd_req_o (rd_req), .rd_ext_o (rd_ext), .rd_addr_o (rd_addr),
      .rd_valid_i (rd_valid), .rd_data_i (rd_data), .shpin_bus_sel_i (shsel),
      .mode_o (mode), .err_o (err), .pins_hiz_o (hiz), .port_en_o (port_en),
      .bus_en_o (bus_en), .shpin_bus_o (sh_bus), .shpin_port_o (sh_port),
      .vec_o (vec), .run_o (run), .cpu_hold_o (hold)
   );

   function automatic logic [7:0] byte_at(input logic [AW-1:0] a, input logic ext);
      if (a == AW'(BASE)) return mem_byte;
      return a[7:0] ^ (ext ? 8'hC3 : 8'h1E) ^ mem_byte;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: answers only an open request, one-cycle valid
   initial begin
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            rd_valid = 1'b0; cnt = 0;
         end else if (rd_valid) begin
            rd_valid = 1'b0; cnt = 0;
         end else if (rd_req) begin
            if (cnt >= lat_cfg) begin
               rd_valid = 1'b1;
               rd_data  = byte_at(rd_addr, rd_ext);
               if (nlog < 8) begin
                  addr_log[nlog] = rd_addr;
                  ext_log[nlog]  = rd_ext;
               end
               nlog++;
            end else cnt++;
         end
      end
   end

   task automatic run_case(input logic [1:0] s, input logic [7:0] mb,
                           input logic sel, input int lat);
      bit int_src, ext_src, exp_err, seen_run;
      logic [1:0] exp_mode;
      logic [15:0] exp_vec;
      strap = s; mem_byte = mb; shsel = sel; lat_cfg = lat; wake = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      nlog = 0;
      chk(hiz && hold && !rd_req && !run && mode == 2'd0, "R8 reset state",
          {hiz, hold, rd_req, run, mode}, 6'b110000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      strap = ~s;  // R1: late strap change must be ignored
      int_src = (s == 2'b00);
      ext_src = (s == 2'b10);
      if (!int_src && !ext_src) begin
         chk(err == 1'b1, "R3 bad strap err", err, 1);
         chk(nlog == 0 && !rd_req, "R3 no read", nlog, 0);
         chk(hiz && hold, "R8 hiz in err", {hiz, hold}, 2'b11);
         return;
      end
      chk(!err && !rd_req && nlog == 0 && hold, "R1 no read before wake",
          {err, rd_req, hold}, 3'b001);
      wake = 1'b1;
      seen_run = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (i < 3 && hiz !== 1'b1) chk(0, "R8 hiz during fetch", hiz, 1);
         if (run || err) begin
            seen_run = run;
            break;
         end
      end
      exp_err  = 1'b1;
      exp_mode = 2'd0;
      if (int_src && mb == 8'h00) begin exp_err = 0; exp_mode = 2'd1; end
      if (ext_src && mb == 8'h01) begin exp_err = 0; exp_mode = 2'd2; end
      if (int_src && mb == 8'h01) begin exp_err = 0; exp_mode = 2'd3; end
      chk(nlog == 3, "R4 read count", nlog, 3);
      for (int k = 0; k < 3; k++) begin
         chk(addr_log[k] == AW'(BASE + k), "R4 read address", addr_log[k], BASE + k);
         chk(ext_log[k] == ext_src, "R2 fetch source", ext_log[k], ext_src);
      end
      if (exp_err) begin
         chk(err && !seen_run, "R7 bad byte err", {err, seen_run}, 2'b10);
         chk(hiz && hold && mode == 2'd0, "R7 held in err", {hiz, hold, mode}, 4'b1100);
         repeat (2) @(negedge clk);
         chk(!run && err, "R7 never runs", {run, err}, 2'b01);
      end else begin
         exp_vec = {byte_at(AW'(BASE + 1), ext_src), byte_at(AW'(BASE + 2), ext_src)};
         chk(seen_run, "R11 run strobe", seen_run, 1);
         chk(mode == exp_mode, "R6 mode", mode, exp_mode);
         chk(vec == exp_vec, "R5 vector", vec, exp_vec);
         chk(!hiz && !err, "R8 pins released", {hiz, err}, 0);
         chk(port_en == (exp_mode == 2'd1) && bus_en == (exp_mode != 2'd1),
             "R9 pin function", {port_en, bus_en}, {exp_mode == 2'd1, exp_mode != 2'd1});
         chk(sh_bus == (exp_mode != 2'd1 && sel) && sh_port == (exp_mode != 2'd1 && !sel),
             "R10 shared pins", {sh_bus, sh_port},
             {exp_mode != 2'd1 && sel, exp_mode != 2'd1 && !sel});
         @(negedge clk);
         chk(!run && !hold, "R11 single cycle", {run, hold}, 0);
         shsel = ~sel;
         #1;
         chk(sh_bus == (exp_mode != 2'd1 && !sel), "R10 select follows", sh_bus,
             exp_mode != 2'd1 && !sel);
      end
   endtask

   initial begin
      int wd;
      wd = 0;
      fork
         begin
            // R12: reset in the middle of the fetch
            strap = 2'b00; mem_byte = 8'h01; lat_cfg = 2; wake = 1'b1;
            repeat (2) @(negedge clk);
            nlog = 0;
            rst_n = 1'b1;
            while (nlog < 2) @(negedge clk);
            rst_n = 1'b0;
            #1;
            chk(hiz && !rd_req && hold && mode == 2'd0, "R12 reset mid-fetch",
                {hiz, rd_req, hold, mode}, 5'b10100);
            @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            chk(!rd_req || wake, "R12 restart", rd_req, 0);
            for (int s = 0; s < 4; s++)
               for (int b = 0; b < 256; b++)
                  run_case(2'(s), 8'(b), b[1], b % 3);
            // R12: reset during error state restarts into a good mode
            run_case(2'b01, 8'h00, 1'b0, 0);
            run_case(2'b00, 8'h00, 1'b1, 1);
         end
         begin
            while (wd < 200000) begin
               @(posedge clk);
               wd++;
            end
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=0", wd);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule